// File: doc/BRIEF.md
# Two-Wire Bus Bit-Bang Register

This block lets software drive a two-wire serial bus (one clock line, one data line) directly, one bit at a time. It sits on a simple 32-bit register bus inside a 4 KiB window. A two-bit output latch holds the wanted level of each line. Software raises latch bits through a set port and lowers them through a clear port. Each latch bit drives an open-drain pad: the pad pulls the line low or releases it.

A read of the status port returns the clock latch bit. It also returns the data line level seen on the pad, after a synchroniser. Software can therefore sample acknowledge and read bits that a remote device drives. An access that decodes to no valid port is flagged with a one-cycle error pulse. No register changes on such an access.

Top module: `twb_bitbang_reg`

## Requirements
- R1: After reset the latch is 2'b11, so both pad output enables are low and both lines are released. The error flag is low.
- R2: A write to offset 0x000 ORs write-data bits [1:0] into the latch. Bit 0 belongs to the clock line and bit 1 to the data line. Latch bits whose data bit is 0 keep their value, and write-data bits 31:2 are ignored.
- R3: A write to offset 0x004 clears each latch bit whose write-data bit (0 = clock, 1 = data) is 1. The other latch bits are unchanged.
- R4: The pad output enable of a line is 1 (drive low) exactly when its latch bit is 0. It is 0 (released) when the latch bit is 1. The change appears in the cycle after the write.
- R5: A read at offset 0x000 returns the clock latch bit in bit 0 and the synchronised data line level in bit 1. Bits 31:2 read as zero and the error flag stays low.
- R6: A change on the data line input appears in the read data after two rising clock edges and not after one.
- R7: A read at any offset other than 0x000 returns 0xFFFF_FFFF, and the error flag is high in the same cycle.
- R8: A write to any offset other than 0x000 or 0x004 leaves the latch unchanged, and the error flag is high in the same cycle.
- R9: The error flag is low in any cycle without an access request and in any cycle with a valid access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Byte offset inside the window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the cycle of a read request |
| err | output | 1 | Access error pulse, same cycle as the access |
| sda_in | input | 1 | Sensed level of the data line pad |
| scl_oe | output | 1 | Clock pad output enable (1 = pull low) |
| sda_oe | output | 1 | Data pad output enable (1 = pull low) |

## Verification
The bench applies every start state of the latch together with every low-bit pattern of the write data at both ports. A design that mixed up the set and clear polarity, or that overwrote the latch instead of merging into it, would leave a wrong pair of pad enables. The bench also uses write data whose upper bits are set. A design that did not mask those bits would show them in read data or corrupt the latch. A sweep of unmapped and misaligned offsets targets decoders that compare only some address bits. Such a decoder would alias a set or clear port and change the latch, or miss the error pulse. The data line check samples after one edge and after two. A synchroniser with the wrong depth would show the new level too early or too late.

// File: rtl/twb_bitbang_reg.sv
module twb_bitbang_reg #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] SET_OFS = 12'h000,
  parameter logic [ADDR_W-1:0] CLR_OFS = 12'h004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              err,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  localparam int LINES = 2;

  logic [LINES-1:0]       lat;
  logic [SYNC_STAGES-1:0] sda_sync;
  logic                   hit_set, hit_clr, wr_set, wr_clr, rd_ok, sda_seen;
  logic                   unused_wdata_hi;

  assign hit_set = (addr == SET_OFS);
  assign hit_clr = (addr == CLR_OFS);
  assign wr_set  = req & we & hit_set;
  assign wr_clr  = req & we & hit_clr;
  assign rd_ok   = req & ~we & hit_set;
  assign unused_wdata_hi = ^wdata[DATA_W-1:LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat <= '1;
    else if (wr_set) lat <= lat | wdata[LINES-1:0];
    else if (wr_clr) lat <= lat & ~wdata[LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sda_sync <= '1;
    else        sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
  end
  assign sda_seen = sda_sync[SYNC_STAGES-1];

  assign rdata = rd_ok ? {{(DATA_W-LINES){1'b0}}, sda_seen, lat[0]}
               : (req & ~we) ? '1 : '0;
  assign err   = req & (we ? ~(hit_set | hit_clr) : ~hit_set);

  assign scl_oe = ~lat[0];
  assign sda_oe = ~lat[1];

  assert_set_data_releases_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && addr == SET_OFS && wdata[1] |=> !sda_oe);
  assert_clr_clock_pulls_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && addr == CLR_OFS && wdata[0] |=> scl_oe);
  assert_read_matches_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we && addr == SET_OFS |-> rdata[0] == !scl_oe && rdata[DATA_W-1:LINES] == '0 && !err);
  assert_bad_read_ones_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req && !we && addr != SET_OFS |-> rdata == '1 && err);
  assert_bad_write_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && addr != SET_OFS && addr != CLR_OFS |=> $stable({scl_oe, sda_oe}));
  assert_idle_no_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !err);
endmodule

// File: tb/twb_bitbang_reg_tb.sv
module twb_bitbang_reg_tb;
  logic clk = 0, rst_n = 0, req = 0, we = 0, sda_in = 1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic err, scl_oe, sda_oe;
  int n_vec = 0, n_bad = 0;
  logic [31:0] cap_rd;
  logic cap_err;

  always #2.5 clk = ~clk;

  twb_bitbang_reg u_dut (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .err(err), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    #1 cap_rd = rdata; cap_err = err;
    @(posedge clk); #0.5;
    req = 0; we = 0; addr = '0; wdata = '0;
  endtask

  function automatic logic [1:0] pads();
    return {~sda_oe, ~scl_oe};
  endfunction

  task automatic put(input logic [1:0] s);
    acc(1, 12'h004, 32'h3);
    acc(1, 12'h000, {30'd0, s});
  endtask

  initial begin
    #(200000 * 5);
    n_vec++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #12 @(negedge clk);
    chk("R1 latch", {30'd0, pads()}, 32'h3);
    chk("R1 err", {31'd0, err}, 0);
    rst_n = 1;
    @(negedge clk); #1;
    chk("R9 idle err", {31'd0, err}, 0);

    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 8; d++) begin
        logic [31:0] dv;
        dv = {(d[2] ? 30'h2AAAAAA8 >> 2 : 30'd0), d[1:0]};
        put(s[1:0]);
        acc(1, 12'h000, dv);
        chk("R9 set err", {31'd0, cap_err}, 0);
        @(negedge clk);
        chk("R2 set merge", {30'd0, pads()}, {30'd0, s[1:0] | d[1:0]});
        chk("R4 oe", {30'd0, sda_oe, scl_oe}, {30'd0, ~(s[1:0] | d[1:0])});
        put(s[1:0]);
        acc(1, 12'h004, dv);
        chk("R9 clr err", {31'd0, cap_err}, 0);
        @(negedge clk);
        chk("R3 clr", {30'd0, pads()}, {30'd0, s[1:0] & ~d[1:0]});
        acc(0, 12'h000, 0);
        chk("R5 read", cap_rd, {30'd0, 1'b1, s[0] & ~d[0]});
        chk("R5 err", {31'd0, cap_err}, 0);
      end

    for (int i = 0; i < 8; i++) begin
      logic [11:0] a;
      a = (i == 0) ? 12'h001 : (i == 1) ? 12'h002 : (i == 2) ? 12'h003 : (i == 3) ? 12'h008 :
          (i == 4) ? 12'h005 : (i == 5) ? 12'h800 : (i == 6) ? 12'hFFC : 12'h400;
      put(2'b01);
      acc(1, a, 32'hFFFF_FFFF);
      chk("R8 bad write err", {31'd0, cap_err}, 1);
      @(negedge clk);
      chk("R8 latch kept", {30'd0, pads()}, 32'h1);
      acc(0, a, 0);
      chk("R7 bad read data", cap_rd, 32'hFFFF_FFFF);
      chk("R7 bad read err", {31'd0, cap_err}, 1);
    end
    acc(0, 12'h004, 0);
    chk("R7 clr port read", cap_rd, 32'hFFFF_FFFF);
    chk("R7 clr port err", {31'd0, cap_err}, 1);

    put(2'b11);
    for (int v = 0; v < 2; v++) begin
      @(negedge clk); sda_in = v[0];
      @(negedge clk); req = 1; we = 0; addr = 12'h000; #1;
      chk("R6 one edge", {31'd0, rdata[1]}, {31'd0, ~v[0]});
      @(negedge clk); #1;
      chk("R6 two edges", {31'd0, rdata[1]}, {31'd0, v[0]});
      chk("R5 sensed", rdata, {30'd0, v[0], 1'b1});
      req = 0;
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule